// File: doc/BRIEF.md
# Serial Pseudorandom Pattern Checker with Sync and Error Counting

This block checks a serial receive stream against a pseudorandom sequence whose feedback is set by a tap mask and an order value. These are the same settings the transmit generator uses. The checker needs no seed and no alignment from outside. While hunting, it fills a local history register with received bits, then checks that its predictions keep matching the stream. After a clean run it declares pattern lock. Once locked, it watches how dense the mismatches are, and drops back to hunting when they crowd together.

Two wide saturating accumulators run alongside the checker. One counts every enabled receive bit. The other counts mismatches seen while locked. A rising edge on a latch control moves both totals into readout registers and restarts both accumulators from zero, so software can measure an error rate over any interval. A sticky loss flag records that lock was lost until the host clears it. A live lock output shows the present state.

Top module: `prbs_rx_checker`

## Requirements
- R1: On a clock edge where `rx_en` is low, the received bit is ignored: the lock state, the history register and both accumulators keep their values.
- R2: The prediction for each bit is the XOR of the earlier received bits selected by `tap_mask`, where mask bit k-1 selects the bit received k positions earlier. After a hunt starts, the first `order_n` enabled bits are only loaded. The next 50 enabled bits must each match the prediction. `in_sync` goes high immediately after the (`order_n`+50)th enabled bit and is still low after the (`order_n`+49)th.
- R3: A mismatch during qualification restarts the hunt: `order_n` bits are loaded again, followed by 50 fresh correct predictions.
- R4: While locked, the predicted bit (not the received bit) enters the history register, so a single flipped bit counts as exactly one error.
- R5: While locked, the checker keeps a sliding record of the last 64 enabled bits. It loses lock on the enabled edge whose error brings the count in that record to 6. Five errors in the record keep lock. After a loss, a new hunt starts on its own.
- R6: `los_sticky` goes high on each loss of lock and stays high until `los_clear` is sampled high. If a loss and a clear occur on the same edge, the flag is set.
- R7: A rising edge on `resync_req` forces a new hunt. `in_sync` is low after that edge, and `los_sticky` is not set by it.
- R8: The bit accumulator counts every enabled edge, whether locked or not.
- R9: The error accumulator counts mismatches only on enabled edges taken while `in_sync` is high. Mismatches during the hunt are not counted.
- R10: On the first edge that samples `latch_req` high after it was low, `bit_snap` and `err_snap` take the accumulated totals. The accumulators restart at zero, or at one for a bit or error arriving on that same edge. Holding `latch_req` high causes no further transfers.
- R11: Each accumulator holds at all ones (width `CNT_W`, 48 by default) instead of wrapping.
- R12: After reset, `in_sync` and `los_sticky` are low, and both snapshots and both accumulators are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock; data sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive clock enable; high marks an edge that carries a bit |
| rx_bit | input | 1 | Serial receive data |
| order_n | input | ORD_W | Polynomial order, 1 to MAX_ORDER |
| tap_mask | input | MAX_ORDER | Feedback taps; bit k-1 selects the bit k positions back |
| resync_req | input | 1 | Rising edge restarts the hunt |
| latch_req | input | 1 | Rising edge moves totals to snapshots and clears accumulators |
| los_clear | input | 1 | Clears the sticky loss flag |
| in_sync | output | 1 | Live pattern-lock indication |
| los_sticky | output | 1 | Sticky loss-of-lock flag |
| bit_snap | output | CNT_W | Latched enabled-bit total |
| err_snap | output | CNT_W | Latched error total |

## Verification
The assertions rely on `order_n` staying at least 1 and no larger than `MAX_ORDER`. They also rely on `tap_mask`, `order_n` and the polynomial staying fixed during a hunt or a lock. The bench respects this by changing the configuration only on cycles where `rx_en` is low, and by following every change with a `resync_req` edge. The bench also keeps `latch_req` and `resync_req` edges on cycles where `rx_en` is low, except for the one case that checks a bit arriving on the latch edge. It builds the reference stream with its own tap-mask generator, and injects errors only by flipping chosen bits of that stream.

// File: rtl/prbs_rx_pkg.sv
package prbs_rx_pkg;
  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_QUAL = 2'd1,
    ST_LOCK = 2'd2
  } sync_st_t;
endpackage

// File: rtl/prbs_rx_predict.sv
module prbs_rx_predict #(
  parameter int MAX_ORDER = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic                 shift_val,
  input  logic [MAX_ORDER-1:0] tap_mask,
  output logic                 pred
);
  // bit 0 holds the most recent bit, bit k-1 the bit k positions back
  logic [MAX_ORDER-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q <= {hist_q[MAX_ORDER-2:0], shift_val};
    end
  end

  always_comb begin
    pred = ^(hist_q & tap_mask);
  end

  // R1: history frozen on idle edges
  assert_hist_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist_q));
endmodule

// File: rtl/prbs_rx_errwin.sv
module prbs_rx_errwin #(
  parameter int WIN_LEN  = 64,
  parameter int LOS_ERRS = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  input  logic err,
  output logic dense
);
  localparam int CW = $clog2(WIN_LEN + 1);

  logic [WIN_LEN-1:0] win_q;
  logic [CW-1:0]      cnt_q;
  logic [CW-1:0]      cnt_nx;

  always_comb begin
    cnt_nx = cnt_q + CW'(err) - CW'(win_q[WIN_LEN-1]);
    dense  = step && (32'(cnt_nx) >= LOS_ERRS);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (step) begin
      win_q <= {win_q[WIN_LEN-2:0], err};
      cnt_q <= cnt_nx;
    end
  end

  // R5: running tally agrees with the record and never rests at the limit
  assert_tally_R5: assert property (@(posedge clk) disable iff (rst)
    32'(cnt_q) == $countones(win_q));
  assert_below_limit_R5: assert property (@(posedge clk) disable iff (rst)
    32'(cnt_q) < LOS_ERRS);
endmodule

// File: rtl/prbs_rx_syncfsm.sv
module prbs_rx_syncfsm
  import prbs_rx_pkg::*;
#(
  parameter int MAX_ORDER = 32,
  parameter int QUAL_BITS = 50,
  localparam int ORD_W = $clog2(MAX_ORDER + 1),
  localparam int HC_W  = $clog2(MAX_ORDER + QUAL_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic             rx_bit,
  input  logic [ORD_W-1:0] order_n,
  input  logic             pred,
  input  logic             resync_pulse,
  input  logic             los_clear,
  input  logic             dense,
  output logic             shift_en,
  output logic             shift_val,
  output logic             win_step,
  output logic             win_clr,
  output logic             err_hit,
  output logic             in_sync,
  output logic             los_sticky
);
  sync_st_t        st_q;
  logic [HC_W-1:0] hc_q;
  logic            mism;
  logic            loss;

  always_comb begin
    mism      = rx_bit ^ pred;
    shift_en  = rx_en && !resync_pulse;
    shift_val = (st_q == ST_LOCK) ? pred : rx_bit;
    win_step  = shift_en && (st_q == ST_LOCK);
    err_hit   = win_step && mism;
    loss      = win_step && dense;
    win_clr   = resync_pulse || loss;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_LOAD;
      hc_q       <= '0;
      in_sync    <= 1'b0;
      los_sticky <= 1'b0;
    end else begin
      if (los_clear) los_sticky <= 1'b0;
      if (resync_pulse) begin
        st_q    <= ST_LOAD;
        hc_q    <= '0;
        in_sync <= 1'b0;
      end else if (rx_en) begin
        unique case (st_q)
          ST_LOAD: begin
            if (32'(hc_q) + 32'd1 >= 32'(order_n)) begin
              st_q <= ST_QUAL;
              hc_q <= '0;
            end else begin
              hc_q <= hc_q + HC_W'(1);
            end
          end
          ST_QUAL: begin
            if (mism) begin
              st_q <= ST_LOAD;
              hc_q <= '0;
            end else if (32'(hc_q) == QUAL_BITS - 1) begin
              st_q    <= ST_LOCK;
              hc_q    <= '0;
              in_sync <= 1'b1;
            end else begin
              hc_q <= hc_q + HC_W'(1);
            end
          end
          ST_LOCK: begin
            if (dense) begin
              st_q       <= ST_LOAD;
              hc_q       <= '0;
              in_sync    <= 1'b0;
              los_sticky <= 1'b1;
            end
          end
          default: begin
            st_q <= ST_LOAD;
            hc_q <= '0;
          end
        endcase
      end
    end
  end

  // R7: resync edge ends any lock
  assert_resync_drop_R7: assert property (@(posedge clk) disable iff (rst)
    resync_pulse |=> !in_sync);
  // R6: loss flag persists until cleared
  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (los_sticky && !los_clear) |=> los_sticky);
  // R3: lock only ever follows qualification
  assert_lock_path_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(in_sync) |-> $past(st_q == ST_QUAL));
  // R1: lock state frozen on idle edges
  assert_state_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !resync_pulse) |=> $stable(in_sync));
endmodule

// File: rtl/prbs_rx_satcnt.sv
module prbs_rx_satcnt #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             latch,
  output logic [CNT_W-1:0] snap
);
  logic [CNT_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      snap  <= '0;
    end else if (latch) begin
      snap  <= acc_q;
      acc_q <= CNT_W'(inc);
    end else if (inc && (acc_q != '1)) begin
      acc_q <= acc_q + CNT_W'(1);
    end
  end

  // R11: full count is held
  assert_no_wrap_R11: assert property (@(posedge clk) disable iff (rst)
    (acc_q == '1 && !latch) |=> acc_q == '1);
  // R10: transfer restarts the accumulation
  assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
    latch |=> acc_q <= CNT_W'(1));
  // R1: no change without an increment or a transfer
  assert_acc_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (!inc && !latch) |=> $stable(acc_q));
endmodule

// File: rtl/prbs_rx_checker.sv
module prbs_rx_checker #(
  parameter int MAX_ORDER = 32,
  parameter int CNT_W     = 48,
  parameter int WIN_LEN   = 64,
  parameter int LOS_ERRS  = 6,
  parameter int QUAL_BITS = 50,
  localparam int ORD_W = $clog2(MAX_ORDER + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_en,
  input  logic                 rx_bit,
  input  logic [ORD_W-1:0]     order_n,
  input  logic [MAX_ORDER-1:0] tap_mask,
  input  logic                 resync_req,
  input  logic                 latch_req,
  input  logic                 los_clear,
  output logic                 in_sync,
  output logic                 los_sticky,
  output logic [CNT_W-1:0]     bit_snap,
  output logic [CNT_W-1:0]     err_snap
);
  logic resync_d, latch_d;
  logic resync_pulse, latch_pulse;
  logic pred, shift_en, shift_val;
  logic win_step, win_clr, err_hit, dense;
  logic [1:0]       cnt_inc;
  logic [CNT_W-1:0] cnt_snap [2];

  always_ff @(posedge clk) begin
    if (rst) begin
      resync_d <= 1'b0;
      latch_d  <= 1'b0;
    end else begin
      resync_d <= resync_req;
      latch_d  <= latch_req;
    end
  end

  always_comb begin
    resync_pulse = resync_req && !resync_d;
    latch_pulse  = latch_req && !latch_d;
    cnt_inc[0]   = rx_en;
    cnt_inc[1]   = err_hit;
    bit_snap     = cnt_snap[0];
    err_snap     = cnt_snap[1];
  end

  prbs_rx_predict #(.MAX_ORDER(MAX_ORDER)) predict_i (
    .clk(clk), .rst(rst), .shift_en(shift_en), .shift_val(shift_val),
    .tap_mask(tap_mask), .pred(pred)
  );

  prbs_rx_errwin #(.WIN_LEN(WIN_LEN), .LOS_ERRS(LOS_ERRS)) errwin_i (
    .clk(clk), .rst(rst), .clr(win_clr), .step(win_step), .err(err_hit),
    .dense(dense)
  );

  prbs_rx_syncfsm #(.MAX_ORDER(MAX_ORDER), .QUAL_BITS(QUAL_BITS)) fsm_i (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rx_bit(rx_bit), .order_n(order_n),
    .pred(pred), .resync_pulse(resync_pulse), .los_clear(los_clear),
    .dense(dense), .shift_en(shift_en), .shift_val(shift_val),
    .win_step(win_step), .win_clr(win_clr), .err_hit(err_hit),
    .in_sync(in_sync), .los_sticky(los_sticky)
  );

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    prbs_rx_satcnt #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst(rst), .inc(cnt_inc[g]), .latch(latch_pulse),
      .snap(cnt_snap[g])
    );
  end

  // R9: errors are only tallied while locked
  assert_err_gate_R9: assert property (@(posedge clk) disable iff (rst)
    !in_sync |-> !err_hit);
  // R10: snapshots move only on a latch edge
  assert_snap_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !latch_pulse |=> ($stable(bit_snap) && $stable(err_snap)));
endmodule

// File: tb/prbs_rx_checker_tb_top.sv
module prbs_rx_checker_tb_top;
  localparam int MAXN = 32;
  localparam int CW   = 12;
  localparam int OW   = $clog2(MAXN + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b0, rx_bit = 1'b0;
  logic [OW-1:0]   order_n = OW'(7);
  logic [MAXN-1:0] tap_mask = 32'h60;
  logic resync_req = 1'b0, latch_req = 1'b0, los_clear = 1'b0;
  logic in_sync, los_sticky;
  logic [CW-1:0] bit_snap, err_snap;

  int nchk = 0, nerr = 0, en_since = 0;
  bit done = 1'b0;
  logic [MAXN-1:0] gen = '1;
  logic [MAXN-1:0] gmask = 32'h60;

  always #10 clk = ~clk;

  prbs_rx_checker #(.MAX_ORDER(MAXN), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rx_bit(rx_bit), .order_n(order_n),
    .tap_mask(tap_mask), .resync_req(resync_req), .latch_req(latch_req),
    .los_clear(los_clear), .in_sync(in_sync), .los_sticky(los_sticky),
    .bit_snap(bit_snap), .err_snap(err_snap)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic flip);
    logic b;
    b = ^(gen & gmask);
    rx_en = 1'b1;
    rx_bit = b ^ flip;
    gen = {gen[MAXN-2:0], b};
    en_since++;
    tick();
    rx_en = 1'b0;
  endtask

  task automatic send_n(input int n);
    for (int i = 0; i < n; i++) send(1'b0);
  endtask

  task automatic start(input int n, input logic [MAXN-1:0] m);
    order_n = OW'(n);
    tap_mask = m;
    gmask = m;
    gen = '0;
    for (int i = 0; i < n; i++) gen[i] = 1'b1;
    resync_req = 1'b1;
    tick();
    resync_req = 1'b0;
    tick();
  endtask

  task automatic do_latch();
    latch_req = 1'b1;
    tick();
    latch_req = 1'b0;
    tick();
    en_since = 0;
  endtask

  initial begin
    int ords [5];
    logic [MAXN-1:0] msks [5];
    ords = '{7, 9, 15, 23, 31};
    msks = '{32'h60, 32'h110, 32'h6000, 32'h420000, 32'h48000000};

    repeat (3) tick();
    rst = 1'b0;
    tick();
    check("R12 in_sync", in_sync, 0);
    check("R12 los_sticky", los_sticky, 0);
    check("R12 bit_snap", bit_snap, 0);
    check("R12 err_snap", err_snap, 0);
    do_latch();
    check("R12 accumulators zero", bit_snap + err_snap, 0);

    // R2 lock time across orders
    for (int k = 0; k < 5; k++) begin
      start(ords[k], msks[k]);
      send_n(ords[k] + 49);
      check("R2 not yet locked", in_sync, 0);
      send(1'b0);
      check("R2 locked at n+50", in_sync, 1);
    end

    // R3 mismatch during qualification restarts the hunt
    do_latch();
    start(7, 32'h60);
    send_n(26);
    send(1'b1);
    send_n(7 + 49);
    check("R3 not locked after restart n+49", in_sync, 0);
    send(1'b0);
    check("R3 locked after restart n+50", in_sync, 1);
    do_latch();
    check("R9 hunt mismatch not counted", err_snap, 0);

    // R4/R5 spacing 13: never 6 in 64
    start(15, 32'h6000);
    send_n(65);
    check("R2 lock n=15", in_sync, 1);
    do_latch();
    for (int i = 0; i < 10; i++) begin
      send(1'b1);
      send_n(12);
    end
    check("R5 sparse errors keep lock", in_sync, 1);
    check("R6 no loss yet", los_sticky, 0);
    do_latch();
    check("R4 one count per flipped bit", err_snap, 10);
    check("R8 bit count", bit_snap, 130);

    // R1 idle edges ignored
    for (int i = 0; i < 40; i++) begin
      rx_bit = i[0] ^ i[2];
      tick();
    end
    send_n(20);
    check("R1 lock kept over idle", in_sync, 1);
    do_latch();
    check("R1 idle edges not counted", bit_snap, 20);
    check("R1 idle garbage no errors", err_snap, 0);

    // R5 spacing 12: sixth error loses lock
    for (int i = 0; i < 5; i++) begin
      send(1'b1);
      send_n(11);
    end
    check("R5 five errors keep lock", in_sync, 1);
    send(1'b1);
    check("R5 sixth error drops lock", in_sync, 0);
    check("R6 sticky set on loss", los_sticky, 1);
    send_n(64);
    check("R5 rehunt not yet locked", in_sync, 0);
    send(1'b0);
    check("R5 rehunt locks", in_sync, 1);
    check("R6 sticky held", los_sticky, 1);
    do_latch();
    check("R9 errors while locked", err_snap, 6);
    los_clear = 1'b1;
    tick();
    los_clear = 1'b0;
    check("R6 sticky cleared", los_sticky, 0);

    // R7 resync while locked
    resync_req = 1'b1;
    tick();
    check("R7 resync drops lock", in_sync, 0);
    check("R7 resync leaves sticky low", los_sticky, 0);
    resync_req = 1'b0;
    tick();

    // R10 held latch and same-edge bit
    send_n(65);
    check("R2 relock", in_sync, 1);
    do_latch();
    latch_req = 1'b1;
    tick();
    en_since = 0;
    send_n(10);
    latch_req = 1'b0;
    tick();
    send_n(5);
    do_latch();
    check("R10 held latch single transfer", bit_snap, 15);
    send_n(4);
    latch_req = 1'b1;
    send(1'b0);
    latch_req = 1'b0;
    tick();
    check("R10 snapshot excludes same-edge bit", bit_snap, 4);
    send_n(3);
    do_latch();
    check("R10 same-edge bit in new period", bit_snap, 4);

    // R11 saturation
    send_n(4100);
    do_latch();
    check("R11 bit count saturates", bit_snap, 4095);
    check("R11 lock after long run", in_sync, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule